// File: doc/BRIEF.md
# Serial flash write-enable and sector protection command decoder

This block sits behind the serial pins of a flash device and handles the commands that control write permission. It samples chip select, serial clock and serial data in the system clock domain. While chip select is low it shifts in bytes MSB first on rising serial clock edges: first an opcode, then up to three address bytes. Any bytes after those are counted but not stored.

Nothing takes effect while a command is being shifted in. When chip select rises, the block decides whether to act. A command counts only if a whole, non-zero number of bytes was received. The block keeps a write-enable latch, one protect bit per sector and a sequential-program-mode flag. Other parts of the device read these through the outputs. Sector protect bits come up set after reset. Changing one needs the write-enable latch, and a change that succeeds clears the latch again.

The serial data output is never driven by this block. Its enable output stays low.

Top module: `flash_prot_decoder`

## Requirements
- R1: After reset, every bit of prot_o is 1, wel_o is 0 and seq_mode_o is 0.
- R2: Opcode 8'h06 sets wel_o when chip select rises after it.
- R3: Opcode 8'h04 clears both wel_o and seq_mode_o when chip select rises. Any bytes sent after the opcode make no difference.
- R4: Opcode 8'h36 followed by three address bytes (A23 first) sets the protect bit of the addressed sector. Bytes after the third address byte are ignored. With fewer than three address bytes the command has no effect.
- R5: Opcode 8'h39 followed by three address bytes clears the protect bit of the addressed sector. It follows the same length rules as R4.
- R6: When wel_o is 0 at chip-select rise, opcodes 8'h36, 8'h39 and 8'hAD change nothing.
- R7: A protect or unprotect command that is carried out also clears wel_o.
- R8: The sector index is address bits A19..A16, which gives 16 sectors with the default parameters. A23..A20 and A15..A0 are don't-care.
- R9: A command is aborted and no output changes when chip select rises in either case: fewer than 8 bits were received, or the bit count is not a multiple of 8.
- R10: Opcode 8'hAD followed by three address bytes sets seq_mode_o if wel_o is 1. wel_o is left unchanged.
- R11: Any other opcode has no effect.
- R12: so_oe_o is always 0. wel_o, prot_o and seq_mode_o change only in response to a chip-select rise. They never change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock; data is taken on its rising edge |
| si_i | input | 1 | Serial data in, MSB first |
| wel_o | output | 1 | Write-enable latch |
| prot_o | output | NUM_SECTORS | Per-sector protect bits, 1 = protected |
| seq_mode_o | output | 1 | Sequential program mode flag |
| so_oe_o | output | 1 | Serial data output enable, always 0 |

## Verification
The assertions assume a few things about the serial inputs:
- each serial clock level and each chip-select level lasts longer than the synchronizer delay;
- no serial clock edge arrives in the same sampled cycle as a chip-select edge;
- serial data is stable around each rising serial clock edge.

Under these conditions, a chip-select rise seen by the assertions matches a real end of command. The bench drives every serial clock half-period as four system clock cycles. It waits six cycles around each chip-select edge, and it changes serial data only while the serial clock is low.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam logic [7:0] OPC_WEN    = 8'h06;
  localparam logic [7:0] OPC_WDIS   = 8'h04;
  localparam logic [7:0] OPC_PROT   = 8'h36;
  localparam logic [7:0] OPC_UNPROT = 8'h39;
  localparam logic [7:0] OPC_SEQ    = 8'hAD;

  typedef struct packed {
    logic       valid;      // chip select just rose
    logic       aligned;    // whole, non-zero byte count
    logic       addr_full;  // all address bytes received
    logic [7:0] opcode;
  } frame_t;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sr_q[i] <= RST_VAL;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fpd_shifter.sv
module fpd_shifter
  import fpd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int SEC_LSB    = 16,
  parameter int SEC_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             si_i,
  output frame_t           frame_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             cs_rise_o,
  output logic [2:0]       bit_cnt_o
);
  localparam int KEEP_W = SEC_LSB + SEC_W;
  localparam int MAXB   = ADDR_BYTES + 1;
  localparam int CNT_W  = $clog2(MAXB + 1);

  logic              sck_d, cs_d;
  logic              sck_rise, cs_rise, cs_fall;
  logic [2:0]        bit_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [6:0]        shreg_q;
  logic [7:0]        opc_q;
  logic [KEEP_W-1:0] addr_q;
  logic [7:0]        new_byte;

  assign sck_rise = sck_i & ~sck_d;
  assign cs_rise  = cs_n_i & ~cs_d;
  assign cs_fall  = ~cs_n_i & cs_d;
  assign new_byte = {shreg_q, si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      bit_q   <= '0;
      bytes_q <= '0;
      shreg_q <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
    end else begin
      sck_d <= sck_i;
      cs_d  <= cs_n_i;
      if (cs_fall) begin
        bit_q   <= '0;
        bytes_q <= '0;
      end else if (!cs_n_i && sck_rise) begin
        shreg_q <= new_byte[6:0];
        bit_q   <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (bytes_q == '0) opc_q <= new_byte;
          else if (bytes_q <= CNT_W'(ADDR_BYTES)) addr_q <= KEEP_W'({addr_q, new_byte});
          if (bytes_q != CNT_W'(MAXB)) bytes_q <= bytes_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    frame_o.valid     = cs_rise;
    frame_o.aligned   = (bit_q == 3'd0) && (bytes_q != '0);
    frame_o.addr_full = (bytes_q == CNT_W'(MAXB));
    frame_o.opcode    = opc_q;
  end

  assign sec_o     = addr_q[SEC_LSB +: SEC_W];
  assign cs_rise_o = cs_rise;
  assign bit_cnt_o = bit_q;
endmodule

// File: rtl/fpd_commit.sv
module fpd_commit
  import fpd_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_t           frame_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic             wel_o,
  output logic             seq_o,
  output logic             upd_en_o,
  output logic             upd_val_o,
  output logic [SEC_W-1:0] upd_idx_o
);
  logic wel_q, wel_d, seq_q, seq_d;
  logic fire;

  assign fire = frame_i.valid && frame_i.aligned;

  always_comb begin
    wel_d     = wel_q;
    seq_d     = seq_q;
    upd_en_o  = 1'b0;
    upd_val_o = 1'b0;
    if (fire) begin
      unique case (frame_i.opcode)
        OPC_WEN:  wel_d = 1'b1;
        OPC_WDIS: begin
          wel_d = 1'b0;
          seq_d = 1'b0;
        end
        OPC_PROT, OPC_UNPROT: begin
          if (frame_i.addr_full && wel_q) begin
            upd_en_o  = 1'b1;
            upd_val_o = (frame_i.opcode == OPC_PROT);
            wel_d     = 1'b0;
          end
        end
        OPC_SEQ: if (frame_i.addr_full && wel_q) seq_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      seq_q <= 1'b0;
    end else begin
      wel_q <= wel_d;
      seq_q <= seq_d;
    end
  end

  assign wel_o     = wel_q;
  assign seq_o     = seq_q;
  assign upd_idx_o = sec_i;
endmodule

// File: rtl/fpd_prot_array.sv
module fpd_prot_array #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   upd_en_i,
  input  logic                   upd_val_i,
  input  logic [SEC_W-1:0]       upd_idx_i,
  output logic [NUM_SECTORS-1:0] prot_o
);
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prot_o[g] <= 1'b1;
      else if (upd_en_i && (upd_idx_i == SEC_W'(g))) prot_o[g] <= upd_val_i;
    end
  end
endmodule

// File: rtl/flash_prot_decoder.sv
module flash_prot_decoder
  import fpd_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int ADDR_BYTES  = 3,
  parameter int SEC_LSB     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sck_i,
  input  logic                   si_i,
  output logic                   wel_o,
  output logic [NUM_SECTORS-1:0] prot_o,
  output logic                   seq_mode_o,
  output logic                   so_oe_o
);
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

  logic [2:0]       pins_s;
  frame_t           frame_s;
  logic [SEC_W-1:0] sec_s, upd_idx_s;
  logic             cs_rise_s, upd_en_s, upd_val_s;
  logic [2:0]       bit_cnt_s;

  fpd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   (pins_s)
  );

  fpd_shifter #(.ADDR_BYTES(ADDR_BYTES), .SEC_LSB(SEC_LSB), .SEC_W(SEC_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (pins_s[2]),
    .sck_i    (pins_s[1]),
    .si_i     (pins_s[0]),
    .frame_o  (frame_s),
    .sec_o    (sec_s),
    .cs_rise_o(cs_rise_s),
    .bit_cnt_o(bit_cnt_s)
  );

  fpd_commit #(.SEC_W(SEC_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_s),
    .sec_i    (sec_s),
    .wel_o    (wel_o),
    .seq_o    (seq_mode_o),
    .upd_en_o (upd_en_s),
    .upd_val_o(upd_val_s),
    .upd_idx_o(upd_idx_s)
  );

  fpd_prot_array #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_prot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_en_i (upd_en_s),
    .upd_val_i(upd_val_s),
    .upd_idx_i(upd_idx_s),
    .prot_o   (prot_o)
  );

  assign so_oe_o = 1'b0;
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
  parameter int NUM_SECTORS = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_rise_i,
  input logic [2:0]             bit_cnt_i,
  input logic                   wel_i,
  input logic                   seq_i,
  input logic [NUM_SECTORS-1:0] prot_i,
  input logic                   so_oe_i
);
  p_prot_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(prot_i));
  p_wel_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(wel_i));
  p_seq_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(seq_i));
  p_so_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_i);
  p_need_wel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !wel_i) |=> ($stable(prot_i) && !$rose(seq_i)));
  p_one_sector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> ($countones(prot_i ^ $past(prot_i)) <= 1));
  p_prot_clears_wel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> ((prot_i == $past(prot_i)) || !wel_i));
  p_misaligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && bit_cnt_i != 3'd0) |=> ($stable(wel_i) && $stable(seq_i) && $stable(prot_i)));
endmodule

bind flash_prot_decoder fpd_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_rise_i(cs_rise_s),
  .bit_cnt_i(bit_cnt_s),
  .wel_i    (wel_o),
  .seq_i    (seq_mode_o),
  .prot_i   (prot_o),
  .so_oe_i  (so_oe_o)
);

// File: tb/flash_prot_decoder_tb_top.sv
module flash_prot_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC       = 16;
  localparam int HALF       = 4;

  typedef struct {
    logic            wel;
    logic            seq;
    logic [NSEC-1:0] prot;
    string           tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, si = 1'b0;
  logic wel, seq, so_oe;
  logic [NSEC-1:0] prot;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  logic            m_wel = 1'b0, m_seq = 1'b0;
  logic [NSEC-1:0] m_prot = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prot_decoder #(.NUM_SECTORS(NSEC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .si_i(si),
    .wel_o(wel), .prot_o(prot), .seq_mode_o(seq), .so_oe_o(so_oe)
  );

  task automatic check(input string tag, input logic [NSEC+2:0] act, input logic [NSEC+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {so_oe,wel,seq,prot}=%h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected state and compares with outputs
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      repeat (2) @(negedge clk);
      check(exp_q[0].tag, {so_oe, wel, seq, prot}, {1'b0, exp_q[0].wel, exp_q[0].seq, exp_q[0].prot});
      void'(exp_q.pop_front());
    end
  end

  // d is left-aligned: bit 47 is sent first
  task automatic cmd(input logic [7:0] opc, input logic [23:0] addr, input int nbits, input string tag);
    logic [47:0] d;
    logic aligned, full;
    exp_t e;
    d = {opc, addr, 16'hA5C3};
    cs_ni = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = d[47-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF + 4) @(negedge clk);
    // R12: nothing changes while chip select is low
    check({"R12 hold before deassert / ", tag}, {so_oe, wel, seq, prot}, {1'b0, m_wel, m_seq, m_prot});
    cs_ni = 1'b1;
    repeat (6) @(negedge clk);
    aligned = (nbits % 8 == 0) && (nbits >= 8);
    full    = (nbits >= 32);
    if (aligned) begin
      case (opc)
        8'h06: m_wel = 1'b1;
        8'h04: begin m_wel = 1'b0; m_seq = 1'b0; end
        8'h36, 8'h39: if (full && m_wel) begin
          m_prot[addr[19:16]] = (opc == 8'h36);
          m_wel = 1'b0;
        end
        8'hAD: if (full && m_wel) m_seq = 1'b1;
        default: ;
      endcase
    end
    e.wel = m_wel; e.seq = m_seq; e.prot = m_prot; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", {so_oe, wel, seq, prot}, {1'b0, 1'b0, 1'b0, {NSEC{1'b1}}});
    cmd(8'h06, 24'h0, 8,  "R2 write enable sets wel");
    cmd(8'h04, 24'h0, 8,  "R3 write disable clears wel");
    cmd(8'h39, 24'h05_1234, 32, "R6 unprotect without wel ignored");
    cmd(8'h06, 24'h0, 8,  "R2 write enable again");
    cmd(8'h39, 24'h05_1234, 32, "R5 R7 unprotect sector 5 clears wel");
    cmd(8'h06, 24'h0, 8,  "R2 enable before unprotect");
    cmd(8'h39, 24'hF3_0000, 40, "R8 high address bits ignored, sector 3");
    cmd(8'h06, 24'h0, 8,  "R2 enable before protect");
    cmd(8'h36, 24'h05_FFFF, 48, "R4 protect sector 5 with trailing bytes");
    cmd(8'h06, 24'h0, 8,  "R2 enable before short protect");
    cmd(8'h36, 24'h03_0000, 24, "R4 short address ignored");
    cmd(8'h04, 24'h0, 9,  "R9 nine bits aborts write disable");
    cmd(8'h04, 24'h0, 5,  "R9 partial opcode aborts");
    cmd(8'hAB, 24'h03_0000, 32, "R11 unknown opcode ignored");
    cmd(8'hAD, 24'h00_0000, 32, "R10 sequential mode set, wel kept");
    cmd(8'h04, 24'h77_7777, 24, "R3 write disable with extra bytes ends seq mode");
    cmd(8'hAD, 24'h00_0000, 32, "R6 sequential mode needs wel");
    cmd(8'h06, 24'h0, 7,  "R9 seven-bit enable aborted");
    cmd(8'h06, 24'h0, 16, "R2 enable with trailing byte");
    cmd(8'h36, 24'h0A_0000, 31, "R9 protect one bit short aborted");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule